// File: doc/BRIEF.md
# Multi-cycle 8-bit processor datapath

This block is the register-and-arithmetic half of a small multi-cycle 8-bit processor. An external sequencer drives it one control word per clock: the operand selects, the ALU operation, a load strobe for each architectural register, and memory read and write strobes. All registers take their new value from a single ALU result bus. This means every transfer goes through the ALU, including moves, program counter increments and address formation. The PC increment is an add against a constant-one B operand.

The block holds the program counter, instruction register, memory address and memory data registers, a 4-bit flags register, a four-entry register file and a 256-byte memory. Register-file indices come from fields of the current instruction register. The instruction register and the flags go back to the sequencer. The PC, MAR, MDR and the ALU result bus are also brought out, so that the whole datapath can be observed from its ports.

Top module: `cpu8_datapath`

## Requirements
- R1: When `rst` is high at a rising clock edge, the PC, IR, MAR, MDR, flags and all four register-file entries become zero.
- R2: `a_sel` picks the ALU A operand: 0 is register port A, 1 is the PC, 2 is the MDR and 3 is constant zero. `b_sel` picks the B operand: 0 is register port B and 1 is constant one. Port A reads the entry indexed by IR[3:2], and port B reads the entry indexed by IR[1:0].
- R3: `alu_op` sets the result on `alu_y`, modulo 256: 0 gives A, 1 gives A+B, 2 gives A-B, 3 gives A AND B, 4 gives A OR B, 5 gives A XOR B, 6 gives NOT A, 7 gives B.
- R4: The flag bits are, from bit 3 down to bit 0, zero (result is 0), negative (result bit 7), carry and overflow. Carry is the carry out for an add and the borrow (A < B unsigned) for a subtract. Overflow is signed overflow for an add or a subtract. Carry and overflow are 0 for every other operation. The flags register loads them at an edge where `flags_we` is high and holds otherwise.
- R5: The PC, IR and MAR each take `alu_y` at an edge where their own strobe is high, and keep their value otherwise.
- R6: When `reg_we` is high, `alu_y` is written into the entry indexed by IR[3:2], using the IR value from before that edge, even if the IR loads in the same cycle. No entry changes while `reg_we` is low.
- R7: The MDR loads when `mdr_we` or `mem_rd` is high. With `mem_rd` high it takes the memory byte at the current MAR address, even if `mdr_we` is also high. Otherwise it takes `alu_y`.
- R8: When `mem_wr` is high, the MDR value from before the edge is written to the memory byte at the current MAR address, even if the MDR loads in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_sel | input | 2 | ALU A operand select |
| b_sel | input | 1 | ALU B operand select |
| alu_op | input | 3 | ALU operation code |
| flags_we | input | 1 | Load strobe for the flags register |
| pc_we | input | 1 | Load strobe for the PC |
| ir_we | input | 1 | Load strobe for the IR |
| reg_we | input | 1 | Register-file write strobe |
| mar_we | input | 1 | Load strobe for the MAR |
| mdr_we | input | 1 | Load strobe for the MDR from the ALU |
| mem_rd | input | 1 | Memory read into the MDR |
| mem_wr | input | 1 | Memory write from the MDR |
| alu_y | output | 8 | ALU result bus |
| pc | output | 8 | Program counter |
| ir | output | 8 | Instruction register |
| mar | output | 8 | Memory address register |
| mdr | output | 8 | Memory data register |
| flags | output | 4 | Flags register: zero, negative, carry, overflow |

## Verification
Two pairs of functions can share a cycle.

The first pair is the two MDR load sources. The bench raises `mdr_we` and `mem_rd` together while the ALU presents a value that differs from the addressed byte. It then requires the MDR to hold the memory byte.

The second pair is a memory write with an MDR load. The bench raises `mem_wr` and `mdr_we` in the same cycle. It reads the location back and requires the old MDR value, while the MDR itself must show the new ALU value.

A register write during an IR load is handled the same way. The bench loads the IR and writes a register in one cycle, then reads the entries selected by the old and the new IR indices. Only the old index may have changed.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

    localparam int DATA_W  = 8;
    localparam int FLAG_W  = 4;
    localparam int NUM_REG = 4;
    localparam int ADDR_W  = 8;

    typedef enum logic [2:0] {
        OP_PASS_A = 3'd0,
        OP_ADD    = 3'd1,
        OP_SUB    = 3'd2,
        OP_AND    = 3'd3,
        OP_OR     = 3'd4,
        OP_XOR    = 3'd5,
        OP_NOT_A  = 3'd6,
        OP_PASS_B = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        ASRC_REG  = 2'd0,
        ASRC_PC   = 2'd1,
        ASRC_MDR  = 2'd2,
        ASRC_ZERO = 2'd3
    } a_src_e;

    typedef enum logic {
        BSRC_REG = 1'b0,
        BSRC_ONE = 1'b1
    } b_src_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/cpu8_alu.sv
module cpu8_alu
    import cpu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_op_e       op,
    output logic [DW-1:0] y,
    output flags_t        fl
);

    localparam int MSB = DW - 1;

    logic [DW:0] wide_d;
    logic        carry_d;
    logic        ovf_d;

    always_comb begin
        wide_d  = '0;
        carry_d = 1'b0;
        ovf_d   = 1'b0;
        y       = '0;
        unique case (op)
            OP_PASS_A: y = a;
            OP_ADD: begin
                wide_d  = {1'b0, a} + {1'b0, b};
                y       = wide_d[DW-1:0];
                carry_d = wide_d[DW];
                ovf_d   = (a[MSB] == b[MSB]) && (y[MSB] != a[MSB]);
            end
            OP_SUB: begin
                wide_d  = {1'b0, a} - {1'b0, b};
                y       = wide_d[DW-1:0];
                carry_d = wide_d[DW];
                ovf_d   = (a[MSB] != b[MSB]) && (y[MSB] != a[MSB]);
            end
            OP_AND:    y = a & b;
            OP_OR:     y = a | b;
            OP_XOR:    y = a ^ b;
            OP_NOT_A:  y = ~a;
            OP_PASS_B: y = b;
            default:   y = '0;
        endcase
        fl.z = (y == '0);
        fl.n = y[MSB];
        fl.c = carry_d;
        fl.v = ovf_d;
    end

endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile #(
    parameter int DW   = 8,
    parameter int NREG = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [$clog2(NREG)-1:0] ra_idx,
    input  logic [$clog2(NREG)-1:0] rb_idx,
    input  logic [$clog2(NREG)-1:0] wr_idx,
    input  logic                    we,
    input  logic [DW-1:0]           wdata,
    output logic [DW-1:0]           ra_data,
    output logic [DW-1:0]           rb_data
);

    logic [NREG-1:0][DW-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            regs_d[wr_idx] = wdata;
        end
        if (rst) begin
            regs_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign ra_data = regs_q[ra_idx];
    assign rb_data = regs_q[rb_idx];

    // R6: entries only change through an enabled write
    a_r6_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(regs_q));

    // R6: written entry holds the data presented at the edge
    a_r6_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> regs_q[$past(wr_idx)] == $past(wdata));

    // R1: reset empties every entry
    a_r1_regs_cleared: assert property (@(posedge clk)
        rst |=> regs_q == '0);

endmodule

// File: rtl/cpu8_mem.sv
module cpu8_mem #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0][DW-1:0] mem_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

    // R8: a write stores the data present before the edge at the addressed byte
    a_r8_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> mem_q[$past(addr)] == $past(wdata));

endmodule

// File: rtl/cpu8_datapath.sv
module cpu8_datapath
    import cpu8_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           a_sel,
    input  logic                 b_sel,
    input  logic [2:0]           alu_op,
    input  logic                 flags_we,
    input  logic                 pc_we,
    input  logic                 ir_we,
    input  logic                 reg_we,
    input  logic                 mar_we,
    input  logic                 mdr_we,
    input  logic                 mem_rd,
    input  logic                 mem_wr,
    output logic [DATA_W-1:0]    alu_y,
    output logic [DATA_W-1:0]    pc,
    output logic [DATA_W-1:0]    ir,
    output logic [ADDR_W-1:0]    mar,
    output logic [DATA_W-1:0]    mdr,
    output logic [FLAG_W-1:0]    flags
);

    localparam int IDX_W = $clog2(NUM_REG);

    typedef struct packed {
        logic [DATA_W-1:0] pc;
        logic [DATA_W-1:0] ir;
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] mdr;
        flags_t            flags;
    } core_t;

    core_t st_d, st_q;

    alu_op_e           op_e;
    a_src_e            asrc_e;
    b_src_e            bsrc_e;
    logic [DATA_W-1:0] opa, opb;
    logic [DATA_W-1:0] ra_data, rb_data;
    logic [DATA_W-1:0] mem_rdata;
    logic [DATA_W-1:0] result;
    flags_t            alu_fl;

    assign op_e   = alu_op_e'(alu_op);
    assign asrc_e = a_src_e'(a_sel);
    assign bsrc_e = b_src_e'(b_sel);

    always_comb begin
        unique case (asrc_e)
            ASRC_REG:  opa = ra_data;
            ASRC_PC:   opa = st_q.pc;
            ASRC_MDR:  opa = st_q.mdr;
            default:   opa = '0;
        endcase
        opb = (bsrc_e == BSRC_ONE) ? DATA_W'(1) : rb_data;
    end

    cpu8_alu #(.DW(DATA_W)) alu_i (
        .a  (opa),
        .b  (opb),
        .op (op_e),
        .y  (result),
        .fl (alu_fl)
    );

    cpu8_regfile #(.DW(DATA_W), .NREG(NUM_REG)) rf_i (
        .clk     (clk),
        .rst     (rst),
        .ra_idx  (st_q.ir[2*IDX_W-1:IDX_W]),
        .rb_idx  (st_q.ir[IDX_W-1:0]),
        .wr_idx  (st_q.ir[2*IDX_W-1:IDX_W]),
        .we      (reg_we),
        .wdata   (result),
        .ra_data (ra_data),
        .rb_data (rb_data)
    );

    cpu8_mem #(.DW(DATA_W), .AW(ADDR_W)) mem_i (
        .clk   (clk),
        .rst   (rst),
        .addr  (st_q.mar),
        .we    (mem_wr),
        .wdata (st_q.mdr),
        .rdata (mem_rdata)
    );

    always_comb begin
        st_d = st_q;
        if (pc_we)    st_d.pc    = result;
        if (ir_we)    st_d.ir    = result;
        if (mar_we)   st_d.mar   = result;
        if (flags_we) st_d.flags = alu_fl;
        if (mdr_we || mem_rd) begin
            st_d.mdr = mem_rd ? mem_rdata : result;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign alu_y = result;
    assign pc    = st_q.pc;
    assign ir    = st_q.ir;
    assign mar   = st_q.mar;
    assign mdr   = st_q.mdr;
    assign flags = st_q.flags;

    // R1: synchronous reset clears the architectural registers
    a_r1_core_cleared: assert property (@(posedge clk)
        rst |=> (pc == '0 && ir == '0 && mar == '0 && mdr == '0 && flags == '0));

    // R5: PC holds without its strobe
    a_r5_pc_hold: assert property (@(posedge clk) disable iff (rst)
        !pc_we |=> $stable(pc));

    // R5: IR takes the result bus
    a_r5_ir_load: assert property (@(posedge clk) disable iff (rst)
        ir_we |=> ir == $past(alu_y));

    // R5: MAR holds without its strobe
    a_r5_mar_hold: assert property (@(posedge clk) disable iff (rst)
        !mar_we |=> $stable(mar));

    // R4: flags hold without their strobe
    a_r4_flags_hold: assert property (@(posedge clk) disable iff (rst)
        !flags_we |=> $stable(flags));

    // R7: memory read data wins the MDR input
    a_r7_mdr_from_mem: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> mdr == $past(mem_rdata));

    // R7: MDR holds when neither source is enabled
    a_r7_mdr_hold: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd || mdr_we) |=> $stable(mdr));

endmodule

// File: tb/cpu8_datapath_tb_top.sv
module cpu8_datapath_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] a_sel;
    logic       b_sel;
    logic [2:0] alu_op;
    logic       flags_we, pc_we, ir_we, reg_we, mar_we, mdr_we, mem_rd, mem_wr;
    logic [7:0] alu_y, pc, ir, mar, mdr;
    logic [3:0] flags;

    int n_checks = 0;
    int n_errors = 0;

    int m_pc;
    int m_regs [4];
    int m_mem [256];

    always #(CLK_PERIOD / 2) clk = ~clk;

    cpu8_datapath dut_i (
        .clk(clk), .rst(rst), .a_sel(a_sel), .b_sel(b_sel), .alu_op(alu_op),
        .flags_we(flags_we), .pc_we(pc_we), .ir_we(ir_we), .reg_we(reg_we),
        .mar_we(mar_we), .mdr_we(mdr_we), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .alu_y(alu_y), .pc(pc), .ir(ir), .mar(mar), .mdr(mdr), .flags(flags)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        a_sel = 2'd0; b_sel = 1'b0; alu_op = 3'd0;
        flags_we = 0; pc_we = 0; ir_we = 0; reg_we = 0;
        mar_we = 0; mdr_we = 0; mem_rd = 0; mem_wr = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        idle();
    endtask

    // returns {z,n,c,v,y}
    function automatic logic [11:0] alu_ref(input int op, input int a, input int b);
        int r, sa, sb, s;
        logic c, v;
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        c = 1'b0; v = 1'b0; r = 0;
        case (op)
            0: r = a;
            1: begin r = a + b; c = (r > 255); s = sa + sb; v = (s > 127) || (s < -128); end
            2: begin r = a - b; c = (a < b);   s = sa - sb; v = (s > 127) || (s < -128); end
            3: r = a & b;
            4: r = a | b;
            5: r = a ^ b;
            6: r = 255 - a;
            default: r = b;
        endcase
        r = r & 255;
        return {(r == 0), (r > 127), c, v, 8'(r)};
    endfunction

    task automatic set_pc(input int v);
        a_sel = 2'd1; b_sel = 1'b1; alu_op = 3'd7; pc_we = 1; tick();
        m_pc = 1;
        while (m_pc != v) begin
            a_sel = 2'd1; b_sel = 1'b1; alu_op = 3'd1; pc_we = 1; tick();
            m_pc = (m_pc + 1) & 255;
        end
    endtask

    task automatic set_ir(input int v);
        set_pc(v);
        a_sel = 2'd1; alu_op = 3'd0; ir_we = 1; tick();
    endtask

    task automatic write_reg(input int idx, input int val);
        set_ir(idx * 4);
        set_pc(val);
        a_sel = 2'd1; alu_op = 3'd0; reg_we = 1; tick();
        m_regs[idx] = val;
    endtask

    task automatic read_reg(input string req, input int idx, input int exp);
        set_ir(idx * 4);
        a_sel = 2'd0; alu_op = 3'd0; #1;
        check(req, "register read", int'(alu_y), exp);
        idle();
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog run did not complete");
        finish_run();
    end

    initial begin
        logic [11:0] ref_v;
        int held;
        idle();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1 reset state
        check("R1", "pc", int'(pc), 0);
        check("R1", "ir", int'(ir), 0);
        check("R1", "mar", int'(mar), 0);
        check("R1", "mdr", int'(mdr), 0);
        check("R1", "flags", int'(flags), 0);
        alu_op = 3'd1; #1;
        check("R1", "reg0 via both ports", int'(alu_y), 0);
        idle();

        // load the register file
        write_reg(0, 8'h3C);
        write_reg(1, 8'h81);
        write_reg(2, 8'h7F);
        write_reg(3, 8'hF0);

        // R2 R3 R4 full operation sweep over all port pairs
        for (int ia = 0; ia < 4; ia++) begin
            for (int ib = 0; ib < 4; ib++) begin
                set_ir(ia * 4 + ib);
                for (int op = 0; op < 8; op++) begin
                    ref_v = alu_ref(op, m_regs[ia], m_regs[ib]);
                    a_sel = 2'd0; b_sel = 1'b0; alu_op = 3'(op); flags_we = 1; #1;
                    check("R3", "register operands", int'(alu_y), int'(ref_v[7:0]));
                    tick();
                    check("R4", "flags load", int'(flags), int'(ref_v[11:8]));
                end
                a_sel = 2'd1; b_sel = 1'b1; alu_op = 3'd1; #1;
                check("R2", "pc plus one", int'(alu_y), (m_pc + 1) & 255);
                a_sel = 2'd3; alu_op = 3'd0; #1;
                check("R2", "constant zero A", int'(alu_y), 0);
                idle();
            end
        end

        // R4 flags hold when strobe low; R5 hold of pc/ir/mar
        held = int'(flags);
        a_sel = 2'd3; alu_op = 3'd0; tick();
        check("R4", "flags hold", int'(flags), held);
        check("R5", "pc hold", int'(pc), m_pc);
        check("R5", "ir hold", int'(ir), 15);

        // R3 R4 R5 PC sweep: PC - reg1 over all 256 PC values
        set_ir(8'h01);
        for (int k = 0; k < 256; k++) begin
            ref_v = alu_ref(2, m_pc, m_regs[1]);
            a_sel = 2'd1; b_sel = 1'b0; alu_op = 3'd2; flags_we = 1; #1;
            check("R3", "pc minus reg", int'(alu_y), int'(ref_v[7:0]));
            tick();
            check("R4", "sub flags", int'(flags), int'(ref_v[11:8]));
            a_sel = 2'd1; b_sel = 1'b1; alu_op = 3'd1; pc_we = 1; tick();
            m_pc = (m_pc + 1) & 255;
            check("R5", "pc increment", int'(pc), m_pc);
        end

        // R7 R8 memory fill: mem[a] = ~a
        set_pc(0);
        for (int k = 0; k < 256; k++) begin
            a_sel = 2'd1; alu_op = 3'd0; mar_we = 1; tick();
            check("R5", "mar load", int'(mar), m_pc);
            a_sel = 2'd1; alu_op = 3'd6; mdr_we = 1; tick();
            check("R7", "mdr from alu", int'(mdr), 255 - m_pc);
            mem_wr = 1; a_sel = 2'd1; b_sel = 1'b1; alu_op = 3'd1; pc_we = 1; tick();
            m_mem[m_pc] = 255 - m_pc;
            m_pc = (m_pc + 1) & 255;
        end

        // R7 readback of every byte
        for (int k = 0; k < 256; k++) begin
            a_sel = 2'd1; alu_op = 3'd0; mar_we = 1; tick();
            mem_rd = 1; a_sel = 2'd1; b_sel = 1'b1; alu_op = 3'd1; pc_we = 1; tick();
            check("R7", "memory read", int'(mdr), m_mem[m_pc]);
            m_pc = (m_pc + 1) & 255;
        end
        a_sel = 2'd2; alu_op = 3'd0; #1;
        check("R2", "mdr as A operand", int'(alu_y), m_mem[255]);
        idle();

        // R7 both MDR sources in one cycle: memory wins
        set_pc(8'h40);
        a_sel = 2'd1; alu_op = 3'd0; mar_we = 1; tick();
        mem_rd = 1; mdr_we = 1; a_sel = 2'd1; alu_op = 3'd0; tick();
        check("R7", "mem_rd beats mdr_we", int'(mdr), m_mem[8'h40]);

        // R8 write and MDR load in one cycle: old MDR is stored
        mem_wr = 1; mdr_we = 1; a_sel = 2'd1; alu_op = 3'd0; tick();
        check("R8", "mdr takes new value", int'(mdr), 8'h40);
        mem_rd = 1; tick();
        check("R8", "memory kept old mdr", int'(mdr), m_mem[8'h40]);

        // R6 IR load and register write in one cycle: old index used
        set_ir(8'h08);
        set_pc(8'h5D);
        a_sel = 2'd1; alu_op = 3'd0; ir_we = 1; reg_we = 1; tick();
        check("R5", "ir load", int'(ir), 8'h5D);
        m_regs[2] = 8'h5D;
        read_reg("R6", 2, 8'h5D);
        read_reg("R6", 3, m_regs[3]);
        read_reg("R6", 1, m_regs[1]);
        read_reg("R6", 0, m_regs[0]);

        // R1 mid-run reset clears everything
        rst = 1'b1; tick(); rst = 1'b0;
        check("R1", "pc after reset", int'(pc), 0);
        check("R1", "mdr after reset", int'(mdr), 0);
        check("R1", "flags after reset", int'(flags), 0);
        check("R1", "mar after reset", int'(mar), 0);
        for (int i = 0; i < 4; i++) begin
            read_reg("R1", i, 0);
        end

        finish_run();
    end

endmodule